// File: doc/BRIEF.md
# Double-Buffered Descriptor DMA Channel

This block is a single DMA channel that keeps two descriptor sets, each made of a buffer address, a byte length and a command word. Only one set drives memory traffic at a time. Software fills the idle set while the other one runs. When the running set reaches zero length, the channel moves to the idle set on its own, so the stream continues without a software restart. A per-set done flag records each completion, and the interrupt line is the OR of the two flags.

Each word moved needs a ready signal from the peripheral. The channel then issues one word-sized memory read or write and answers the peripheral with a one-cycle acknowledge. Several copies of the block can share one register window. The `CHAN` parameter sets where the copy decodes its descriptor block (base + 0x20·CHAN) and its control register (control base + 0x10·CHAN).

Top module: `pp_dma_chan`

## Requirements
- R1: Set 0 decodes at DESC = 0x1000 + 0x20·CHAN and set 1 at DESC + 0x10. Within a set, the address is at +0x0, the length at +0x4 and the command at +0x8. The control register is at 0xC00 + 0x10·CHAN. Length bits [1:0] always read 0, and any address not decoded reads 0.
- R2: After reset every register reads 0, `irq` is 0 and `mem_req` is 0.
- R3: When enable (control bit 0) is set, the active set is armed and `per_req` is high, the channel moves words at the set's address, then address+4, and so on, for length/4 words. Address and length hold their advanced values afterwards.
- R4: Command bit 1 selects the direction. When it is 1, the channel writes `per_din` to memory. When it is 0, it reads memory, presents the word on `per_dout`, and raises `per_ack` for exactly one cycle per word.
- R5: A set whose arm bit (command bit 0) is 0 never issues a memory access.
- R6: When the final word is acknowledged, that set's arm bit clears and its done flag (command bit 2) sets. `irq` rises, and control bit 1 (active set, read-only) points to the other set.
- R7: If the other set is armed, it starts with the same one-cycle gap between memory requests as words inside one set.
- R8: Clearing enable stops the channel at the next word boundary. A word already requested completes, and no new one starts until enable is set again. The transfer then resumes where it stopped.
- R9: Writing a command word with bit 2 set clears that set's done flag. `irq` falls once both flags are clear.
- R10: `mem_req` stays high with a stable address and direction until `mem_ack`.
- R11: An armed set with length 0 completes (done set, arm cleared) without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte address in the shared window |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational, 0 if not decoded) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | DW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| per_req | input | 1 | Peripheral ready for one word |
| per_ack | output | 1 | One-cycle pulse per word moved |
| per_din | input | DW | Data from the peripheral |
| per_dout | output | DW | Data read for the peripheral |
| irq | output | 1 | OR of both done flags |

## Verification
The hardest case to reach from the ports is a set switch at a word boundary with no lost cycle. A second hard case is an abort that lands while a word is already in flight. For the switch, the bench arms the running set first and the standby set while the first is busy. It then compares the spacing of request rises across the switch with the spacing inside a set. For the abort, the bench watches the memory acknowledge count and clears enable right after the first word. The request that starts on the same edge must still complete. After that, nothing may move until enable is set again, and then the remaining words must follow in order.

// File: rtl/pp_dma_chan.sv
module pp_dma_chan #(
  parameter int DW        = 32,
  parameter int RAW       = 13,
  parameter int LW        = 16,
  parameter int CHAN      = 2,
  parameter int DESC_BASE = 32'h1000,
  parameter int CTL_BASE  = 32'h0C00
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  input  logic           per_req,
  output logic           per_ack,
  input  logic [DW-1:0]  per_din,
  output logic [DW-1:0]  per_dout,
  output logic           irq
);
  localparam logic [RAW-1:0] DESC = RAW'(DESC_BASE + 32 * CHAN);
  localparam logic [RAW-1:0] CTL  = RAW'(CTL_BASE + 16 * CHAN);

  logic [DW-1:0] addr_q [2];
  logic [LW-1:0] len_q  [2];
  logic [1:0]    arm_q, dir_q, done_q;
  logic          act, en_q, busy;

  wire       desc_hit = reg_addr[RAW-1:5] == DESC[RAW-1:5];
  wire       ctl_hit  = reg_addr[RAW-1:2] == CTL[RAW-1:2];
  wire       wset     = reg_addr[4];
  wire [1:0] fld      = reg_addr[3:2];
  wire       last     = len_q[act] <= LW'(4);

  assign mem_req   = busy;
  assign mem_we    = dir_q[act];
  assign mem_addr  = addr_q[act];
  assign mem_wdata = per_din;
  assign irq       = |done_q;

  always_comb begin
    reg_rdata = '0;
    if (desc_hit)
      case (fld)
        2'd0:    reg_rdata = addr_q[wset];
        2'd1:    reg_rdata[LW-1:0] = len_q[wset];
        2'd2:    reg_rdata[2:0] = {done_q[wset], dir_q[wset], arm_q[wset]};
        default: reg_rdata = '0;
      endcase
    else if (ctl_hit)
      reg_rdata[1:0] = {act, en_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '{default: '0};
      len_q    <= '{default: '0};
      arm_q    <= '0;
      dir_q    <= '0;
      done_q   <= '0;
      act      <= 1'b0;
      en_q     <= 1'b0;
      busy     <= 1'b0;
      per_ack  <= 1'b0;
      per_dout <= '0;
    end else begin
      per_ack <= 1'b0;
      if (reg_we && desc_hit)
        case (fld)
          2'd0: addr_q[wset] <= reg_wdata;
          2'd1: len_q[wset]  <= {reg_wdata[LW-1:2], 2'b00};
          2'd2: begin
            arm_q[wset] <= reg_wdata[0];
            dir_q[wset] <= reg_wdata[1];
            if (reg_wdata[2]) done_q[wset] <= 1'b0;
          end
          default: ;
        endcase
      if (reg_we && ctl_hit) en_q <= reg_wdata[0];

      if (busy) begin
        if (mem_ack) begin
          busy        <= 1'b0;
          per_ack     <= 1'b1;
          addr_q[act] <= addr_q[act] + DW'(4);
          if (!dir_q[act]) per_dout <= mem_rdata;
          if (last) begin
            len_q[act]  <= '0;
            arm_q[act]  <= 1'b0;
            done_q[act] <= 1'b1;
            act         <= ~act;
          end else begin
            len_q[act] <= len_q[act] - LW'(4);
          end
        end
      end else if (en_q && arm_q[act] && len_q[act] == '0) begin
        arm_q[act]  <= 1'b0;
        done_q[act] <= 1'b1;
        act         <= ~act;
      end else if (en_q && arm_q[act] && per_req) begin
        busy <= 1'b1;
      end else if (!arm_q[act] && arm_q[~act]) begin
        act <= ~act;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(arm_q[act]) && $past(en_q)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !reg_we |=> addr_q[$past(act)] == $past(mem_addr) + DW'(4)); // R3
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack); // R4
  AST_SWITCH_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && last |=> act != $past(act)); // R6
endmodule

// File: tb/pp_dma_chan_tb.sv
`timescale 1ns/1ps
module pp_dma_chan_tb;
  localparam logic [12:0] DESC = 13'h1040;
  localparam logic [12:0] CTL  = 13'h0C20;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n = 0, reg_we = 0, mem_ack = 0, per_req = 0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, mem_rdata = '0, per_din = '0;
  logic [31:0] reg_rdata, mem_addr, mem_wdata, per_dout;
  logic        mem_req, mem_we, per_ack, irq;

  pp_dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .per_req(per_req),
    .per_ack(per_ack), .per_din(per_din), .per_dout(per_dout), .irq(irq));

  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } txn_t;
  txn_t exp_q[$];
  int   rise_t[$];
  int   checks = 0, fails = 0, ntx = 0, cyc = 0;

  always @(posedge clk) cyc++;

  function automatic logic [31:0] memval(logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic expect_word(logic we, logic [31:0] a, logic [31:0] d);
    txn_t t;
    t.we = we; t.addr = a; t.data = d;
    exp_q.push_back(t);
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // memory responder and scoreboard monitor
  initial begin
    int w;
    logic [31:0] a0;
    txn_t e;
    w = 0; a0 = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (w == 0) begin a0 = mem_addr; rise_t.push_back(cyc); end
        w++;
        if (w == 2) begin
          w = 0;
          ntx++;
          chk("R10 addr stable", mem_addr, a0);
          if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R3 unexpected access actual=%h expected=none", mem_addr);
          end else begin
            e = exp_q.pop_front();
            chk("R3 address", mem_addr, e.addr);
            chk("R4 direction", {31'b0, mem_we}, {31'b0, e.we});
            if (e.we) chk("R4 write data", mem_wdata, e.data);
          end
          mem_rdata = memval(mem_addr);
          mem_ack = 1;
        end
      end
    end
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base, n;
    cycles(5);
    rst_n = 1;
    cycles(1);

    rd(CTL, d);        chk("R2 control", d, 0);
    rd(DESC + 8, d);   chk("R2 command", d, 0);
    chk("R2 irq", {31'b0, irq}, 0);
    chk("R2 mem_req", {31'b0, mem_req}, 0);

    wr(DESC, 32'h2000_0100);         rd(DESC, d);         chk("R1 set0 addr", d, 32'h2000_0100);
    wr(DESC + 4, 32'h13);            rd(DESC + 4, d);     chk("R1 len low bits", d, 32'h10);
    wr(DESC + 13'h10, 32'h3000_0000); rd(DESC + 13'h10, d); chk("R1 set1 addr", d, 32'h3000_0000);
    rd(DESC + 13'h0C, d);            chk("R1 unused slot", d, 0);
    rd(13'h1000, d);                 chk("R1 other channel", d, 0);

    // R5: enabled, peripheral ready, nothing armed
    per_req = 1;
    wr(CTL, 1);
    cycles(20);
    chk("R5 no access unarmed", ntx, 0);
    rd(CTL, d); chk("R1 control", d, 1);

    // R3/R4 read transfer of three words from set 0
    wr(DESC + 4, 12);
    for (int i = 0; i < 3; i++) expect_word(0, 32'h2000_0100 + 4 * i, 0);
    wr(DESC + 8, 1);
    cycles(40);
    chk("R3 word count", ntx, 3);
    rd(DESC, d);     chk("R3 address advanced", d, 32'h2000_010C);
    rd(DESC + 4, d); chk("R3 length drained", d, 0);
    chk("R4 per_dout", per_dout, memval(32'h2000_0108));
    rd(DESC + 8, d); chk("R6 done set arm clear", d, 4);
    chk("R6 irq", {31'b0, irq}, 1);
    rd(CTL, d);      chk("R6 active set flipped", d, 3);

    wr(DESC + 8, 4);
    rd(DESC + 8, d); chk("R9 done cleared", d, 0);
    chk("R9 irq low", {31'b0, irq}, 0);

    // R7 ping-pong: set1 writes 2 words, then set0 reads 1 word
    per_din = 32'hCAFE_0001;
    wr(DESC + 13'h14, 8);
    wr(DESC, 32'h4000_0000);
    wr(DESC + 4, 4);
    rise_t.delete();
    expect_word(1, 32'h3000_0000, 32'hCAFE_0001);
    expect_word(1, 32'h3000_0004, 32'hCAFE_0001);
    expect_word(0, 32'h4000_0000, 0);
    wr(DESC + 13'h18, 3);
    wr(DESC + 8, 1);
    cycles(40);
    chk("R7 words moved", ntx, 6);
    chk("R7 requests seen", rise_t.size(), 3);
    if (rise_t.size() == 3)
      chk("R7 no extra gap at switch", rise_t[2] - rise_t[1], rise_t[1] - rise_t[0]);
    rd(DESC + 13'h18, d); chk("R6 set1 done", d, 6);
    rd(DESC + 8, d);      chk("R6 set0 done", d, 4);
    rd(CTL, d);           chk("R6 active back to set1", d, 3);
    wr(DESC + 13'h18, 4);
    chk("R9 irq held by other flag", {31'b0, irq}, 1);
    wr(DESC + 8, 4);
    chk("R9 irq low after both", {31'b0, irq}, 0);

    // R8 disable and resume
    per_req = 0;
    wr(CTL, 0);
    wr(DESC, 32'h5000_0000);
    wr(DESC + 4, 16);
    for (int i = 0; i < 4; i++) expect_word(0, 32'h5000_0000 + 4 * i, 0);
    wr(DESC + 8, 1);
    per_req = 1;
    base = ntx;
    cycles(20);
    chk("R8 disabled no access", ntx, base);
    wr(CTL, 1);
    while (ntx < base + 1) @(negedge clk);
    wr(CTL, 0);
    cycles(5);
    n = ntx;
    cycles(20);
    chk("R8 stopped at boundary", ntx, n);
    chk("R8 stopped early", {31'b0, (n - base) < 4}, 1);
    chk("R8 no request pending", {31'b0, mem_req}, 0);
    wr(CTL, 1);
    cycles(40);
    chk("R8 resumed to completion", ntx, base + 4);
    chk("R8 irq", {31'b0, irq}, 1);
    wr(DESC + 8, 4);

    // R11 zero length
    n = ntx;
    wr(DESC + 4, 0);
    wr(DESC + 8, 1);
    cycles(10);
    chk("R11 no access", ntx, n);
    rd(DESC + 8, d); chk("R11 done", d, 4);
    chk("R11 irq", {31'b0, irq}, 1);

    chk("R3 scoreboard empty", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule